// File: doc/BRIEF.md
# Filtered input edge detector

This block conditions one asynchronous line, such as an external count clock or a trigger wire, before it reaches a low-power timer core. The raw line first passes through a two-flop synchronizer into the kernel clock domain. A digital glitch filter then accepts a new level only after it has seen that level on a run of consecutive equal samples. The length of the run is selected by a 2-bit code. The filtered level is driven out, and an edge picker turns its rising edges, falling edges or both into a strobe that lasts one kernel-clock cycle.

The timer core uses the strobe as a count or start event and the level as a clean copy of the input. While the enable is low the filtered level stays at 0 and no strobe is produced. The block runs only from the kernel clock. It never takes its clock from the input line.

Top module: `inflt_edge_det`

## Requirements
- R1: After synchronous reset, `level_o` is 0 and `strobe_o` is 0.
- R2: `flt_sel_i` selects how many consecutive equal synchronized samples are needed to accept a level change: 00 needs 1 sample (no filtering), 01 needs 2, 10 needs 4 and 11 needs 8.
- R3: If the input holds a new level for fewer cycles than the selected sample count, `level_o` does not change.
- R4: `edge_sel_i` chooses the active edges of the filtered level: 00 selects rising, 01 selects falling and 10 selects both.
- R5: `edge_sel_i` = 11 selects no active edge, and `strobe_o` stays 0.
- R6: With `flt_sel_i` = 00, a raw change that is stable before clock edge k appears on `level_o` after edge k+2. In general the change appears after edge k+1+N, where N is the selected sample count.
- R7: Each accepted active edge gives a `strobe_o` pulse of exactly one cycle, in the same cycle that `level_o` takes the new value.
- R8: While `en_i` is 0, `level_o` is forced to 0 at every clock edge and `strobe_o` stays 0, whatever the raw input does.
- R9: `strobe_o` is high only in a cycle where `level_o` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Block enable; when low the level is cleared and strobes are suppressed |
| raw_i | input | 1 | Asynchronous input line |
| flt_sel_i | input | 2 | Filter depth code (1, 2, 4 or 8 samples) |
| edge_sel_i | input | 2 | Active edge code (rising, falling, both, none) |
| level_o | output | 1 | Filtered, synchronized level |
| strobe_o | output | 1 | One-cycle active-edge event |

## Verification
The bench uses the default parameters: a two-stage synchronizer and a largest filter depth of 8. With these values every filter code can be tested with pulses that end just short of the selected depth or that just reach it. The exact latency from a raw change to the filtered level can be counted for the unfiltered case and for the 8-sample case. Edge-code coverage includes both-edge mode and the no-edge code 11. It also covers turning the enable off while the level is high.

// File: rtl/inflt_pkg.sv
package inflt_pkg;

    localparam int unsigned MAX_SAMPLES = 8;
    localparam int unsigned CNT_W       = $clog2(MAX_SAMPLES + 1);

    typedef enum logic [1:0] {
        EDGE_RISE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_e;

    typedef struct packed {
        logic cand;
        logic [CNT_W-1:0] run;
        logic level;
    } flt_state_t;

    function automatic logic [CNT_W-1:0] need_of(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        n = '0;
        n[0] = 1'b1;
        return n << code;
    endfunction

endpackage

// File: rtl/inflt_sync.sv
module inflt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/inflt_filter.sv
module inflt_filter
    import inflt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             d_i,
    input  logic [CNT_W-1:0] need_i,
    output logic             level_o
);
    flt_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d = '0;
        end else if (d_i != st_q.cand) begin
            st_d.cand = d_i;
            st_d.run  = CNT_W'(1);
            if (need_i == CNT_W'(1)) st_d.level = d_i;
        end else if (st_q.run < need_i) begin
            st_d.run = st_q.run + CNT_W'(1);
            if (st_q.run + CNT_W'(1) == need_i) st_d.level = st_q.cand;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign level_o = st_q.level;

    // A fresh candidate cannot pass a filter deeper than one sample at once
    p_mismatch_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (en_i && (d_i != st_q.cand) && (need_i > CNT_W'(1))) |=> $stable(st_q.level));

    p_run_bounded_r2: assert property (@(posedge clk) disable iff (rst)
        st_q.run <= CNT_W'(MAX_SAMPLES));
endmodule

// File: rtl/inflt_edge_pick.sv
module inflt_edge_pick
    import inflt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    input  logic  level_i,
    input  edge_e sel_i,
    output logic  strobe_o
);
    logic prev_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst)        prev_q <= 1'b0;
        else if (!en_i) prev_q <= 1'b0;
        else            prev_q <= level_i;
    end

    assign rise = level_i & ~prev_q;
    assign fall = ~level_i & prev_q;

    always_comb begin
        unique case (sel_i)
            EDGE_RISE: strobe_o = rise;
            EDGE_FALL: strobe_o = fall;
            EDGE_BOTH: strobe_o = rise | fall;
            default:   strobe_o = 1'b0;
        endcase
    end

    // A rising event cannot repeat in the very next cycle
    p_rise_single_r7: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && level_i) |=> !(strobe_o && level_i));
endmodule

// File: rtl/inflt_edge_det.sv
module inflt_edge_det
    import inflt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       raw_i,
    input  logic [1:0] flt_sel_i,
    input  logic [1:0] edge_sel_i,
    output logic       level_o,
    output logic       strobe_o
);
    logic             sync_lvl;
    logic [CNT_W-1:0] need;
    edge_e            sel;

    assign need = need_of(flt_sel_i);
    assign sel  = edge_e'(edge_sel_i);

    inflt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_i),
        .q_o (sync_lvl)
    );

    inflt_filter u_filter (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .d_i     (sync_lvl),
        .need_i  (need),
        .level_o (level_o)
    );

    inflt_edge_pick u_pick (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en_i),
        .level_i  (level_o),
        .sel_i    (sel),
        .strobe_o (strobe_o)
    );

    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!level_o && !strobe_o));

    p_no_edge_code_r5: assert property (@(posedge clk) disable iff (rst)
        (edge_sel_i == 2'b11) |-> !strobe_o);

    p_strobe_on_change_r9: assert property (@(posedge clk) disable iff (rst)
        strobe_o |-> (level_o != $past(level_o)));
endmodule

// File: tb/tb_inflt_edge_det.sv
module tb_inflt_edge_det;
    logic       clk = 1'b0;
    logic       rst;
    logic       en_i;
    logic       raw_i;
    logic [1:0] flt_sel_i;
    logic [1:0] edge_sel_i;
    logic       level_o;
    logic       strobe_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    inflt_edge_det dut (
        .clk(clk), .rst(rst), .en_i(en_i), .raw_i(raw_i),
        .flt_sel_i(flt_sel_i), .edge_sel_i(edge_sel_i),
        .level_o(level_o), .strobe_o(strobe_o)
    );

    // fields: filter code [11:10], edge code [9:8], pulse length [7:0]
    localparam int NV = 10;
    localparam logic [11:0] VEC [NV] = '{
        {2'b00, 2'b00, 8'd1},
        {2'b01, 2'b00, 8'd1},
        {2'b01, 2'b00, 8'd2},
        {2'b10, 2'b01, 8'd3},
        {2'b10, 2'b01, 8'd4},
        {2'b11, 2'b10, 8'd7},
        {2'b11, 2'b10, 8'd8},
        {2'b00, 2'b11, 8'd5},
        {2'b10, 2'b10, 8'd4},
        {2'b11, 2'b00, 8'd12}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_vec(input logic [11:0] v);
        int  need, len, nstr, exp_str;
        bit  seen_hi, exp_rise;
        need = 1 << v[11:10];
        len  = int'(v[7:0]);
        en_i = 1'b0; raw_i = 1'b0;
        flt_sel_i = v[11:10]; edge_sel_i = v[9:8];
        cycles(1);
        en_i = 1'b1;
        cycles(4);
        nstr = 0; seen_hi = 1'b0;
        for (int c = 0; c < len + 30; c++) begin
            raw_i = (c < len);
            @(negedge clk);
            if (level_o)  seen_hi = 1'b1;
            if (strobe_o) nstr++;
        end
        exp_rise = (len >= need);
        case (v[9:8])
            2'b00, 2'b01: exp_str = exp_rise ? 1 : 0;
            2'b10:        exp_str = exp_rise ? 2 : 0;
            default:      exp_str = 0;
        endcase
        // R2 / R3: filter depth accepts or rejects the pulse
        check(seen_hi == exp_rise, "R2/R3 depth", int'(seen_hi), int'(exp_rise));
        // R4 / R5: strobes according to edge code
        check(nstr == exp_str, "R4/R5 edges", nstr, exp_str);
    endtask

    initial begin
        rst = 1'b1; en_i = 1'b0; raw_i = 1'b0;
        flt_sel_i = 2'b00; edge_sel_i = 2'b00;
        cycles(3);
        // R1: reset state
        check(level_o == 1'b0, "R1 level", int'(level_o), 0);
        check(strobe_o == 1'b0, "R1 strobe", int'(strobe_o), 0);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R6 / R7: unfiltered latency of two sync stages plus one
        en_i = 1'b1; flt_sel_i = 2'b00; edge_sel_i = 2'b00; raw_i = 1'b0;
        cycles(6);
        raw_i = 1'b1;
        cycles(2);
        check(level_o == 1'b0, "R6 early", int'(level_o), 0);
        cycles(1);
        check(level_o == 1'b1, "R6 level", int'(level_o), 1);
        check(strobe_o == 1'b1, "R7 strobe on", int'(strobe_o), 1);
        cycles(1);
        check(strobe_o == 1'b0, "R7 strobe off", int'(strobe_o), 0);

        // R6: eight-sample depth, falling edge
        flt_sel_i = 2'b11; edge_sel_i = 2'b01;
        cycles(2);
        raw_i = 1'b0;
        cycles(9);
        check(level_o == 1'b1, "R6 deep early", int'(level_o), 1);
        cycles(1);
        check(level_o == 1'b0, "R6 deep level", int'(level_o), 0);
        check(strobe_o == 1'b1, "R9 fall strobe", int'(strobe_o), 1);

        // R8: disable while high
        flt_sel_i = 2'b00; edge_sel_i = 2'b10; raw_i = 1'b1;
        cycles(5);
        check(level_o == 1'b1, "R8 pre", int'(level_o), 1);
        en_i = 1'b0;
        cycles(1);
        check(level_o == 1'b0, "R8 level", int'(level_o), 0);
        check(strobe_o == 1'b0, "R8 strobe", int'(strobe_o), 0);
        begin
            int n = 0;
            for (int c = 0; c < 12; c++) begin
                raw_i = c[0];
                @(negedge clk);
                if (strobe_o || level_o) n++;
            end
            check(n == 0, "R8 quiet", n, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule